// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the digital frequency-offset waveform that a fractional feedback divider adds to a clock synthesis loop. The synthesizer's output is then swept slowly across a narrow band next to its reference. The offset is a signed number of steps, each step worth 0.025 % of the reference frequency. It follows a symmetric triangle whose full period is a parameterised number of reference clocks (default 1000). That is about a thousand times slower than the clock being modulated.

Software, straps or board logic pick the span (narrow, wide or none) and the placement. Down placement keeps the synthesized frequency at or below the reference. Center placement straddles it evenly. An active-low spread enable forces the offset to zero but leaves the sweep running. A rising edge on an asynchronous restart line returns the sweep to the start of its path. The block also provides a constant zero offset for the unmodulated reference path. It decodes two enable pins into gate signals for a group of five clock outputs and a group of one.

Top module: `ssc_profile_gen`

## Requirements
- R1: With `span_i` = 2'b00 and spread enabled, the sweep amplitude is 50 steps (1.25 %). In down placement the offset after n clocks of a period is -(floor(n/10)) while n ≤ 500, using the default period of 1000 clocks.
- R2: `span_i` = 2'b01 selects an amplitude of 150 steps (3.75 %), with a step position of floor(3n/10) after n clocks. `span_i` = 2'b10 or 2'b11 selects 0 steps, so the offset stays 0.
- R3: With `center_i` = 0 (down placement), the offset starts each period at 0. It falls by one step at a time to minus the amplitude at mid-period, rises back to 0 by the end of the period and never becomes positive. The period is exactly PERIOD_CLKS clocks.
- R4: With `center_i` = 1 (center placement), the offset starts at plus half the amplitude (+25 narrow, +75 wide), reaches minus half the amplitude at mid-period, and stays within ±half the amplitude.
- R5: While `spread_ni` is high, the offset registered at each clock edge is 0. The sweep keeps advancing, so when the enable is lowered again the offset resumes at the current point of the profile.
- R6: A rising edge on `restart_i` passes through a two-flop synchroniser and restarts the period on the third clock edge after it. After that edge the offset is the start value of the profile. A level held high causes no further restart.
- R7: Changes to `span_i` or `center_i` take effect only at the start of a period (a period boundary or a restart). Inside a period the sweep continues with the settings loaded at its start.
- R8: `ref_offset_o` is always 0, whatever the enable, span, placement or restart inputs are.
- R9: `out_en_i` = {first enable, second enable}. At 2'b00 and 2'b01 both gates are low. At 2'b10 only `grp_b_en_o` is high. At 2'b11 both `grp_a_en_o` and `grp_b_en_o` are high.
- R10: While `rst_ni` is low, `offset_o` is 0 and `offset_vld_o` is 0. `offset_vld_o` goes high on the first clock edge after reset is released and stays high. The first clock after reset starts a period.
- R11: Apart from period starts and changes of the spread enable, consecutive offsets differ by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| spread_ni | input | 1 | Spread enable, active low |
| span_i | input | 2 | Amplitude select: 00 narrow, 01 wide, 1x none |
| center_i | input | 1 | Placement: 0 down, 1 center |
| restart_i | input | 1 | Asynchronous profile restart, acts on its rising edge |
| out_en_i | input | 2 | Output-enable pins {first, second} |
| offset_o | output | OFS_W (9) | Signed frequency offset in 0.025 % steps |
| offset_vld_o | output | 1 | Offset valid after reset |
| ref_offset_o | output | OFS_W (9) | Offset for the unmodulated reference path, always 0 |
| grp_a_en_o | output | 1 | Gate for the five-output clock group |
| grp_b_en_o | output | 1 | Gate for the single-output clock group |

## Verification
The properties assume that `spread_ni`, `span_i`, `center_i` and `out_en_i` are synchronous to `clk_i` and settle well away from its rising edge. Only `restart_i` may arrive at any time. They also assume that twice the wide amplitude is smaller than the period, so that a restart always lands on the zero-step point of the profile. The stimulus changes every input on the falling clock edge and keeps the default period and amplitudes. The restart line is toggled asynchronously only through its synchroniser.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Span select encoding: narrow, wide, and two codes meaning no spread.
  typedef enum logic [1:0] {
    SPAN_NARROW = 2'b00,
    SPAN_WIDE   = 2'b01,
    SPAN_NONE0  = 2'b10,
    SPAN_NONE1  = 2'b11
  } span_e;
endpackage

// File: rtl/ssc_restart_sync.sv
module ssc_restart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  // STAGES synchroniser flops plus one history flop for edge detection.
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ssc_sweep_core.sv
module ssc_sweep_core
  import ssc_pkg::*;
#(
  parameter int PERIOD_CLKS  = 1000,
  parameter int NARROW_STEPS = 50,
  parameter int WIDE_STEPS   = 150,
  parameter int AMP_W        = $clog2(WIDE_STEPS + 1),
  parameter int POS_W        = AMP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  span_e            span_i,
  input  logic             center_i,
  output logic             period_start_o,
  output logic [AMP_W-1:0] amp_nxt_o,
  output logic             ctr_nxt_o,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic [AMP_W-1:0] amp_q_o,
  output logic             ctr_q_o
);
  localparam int PH_W  = $clog2(PERIOD_CLKS);
  localparam int ACC_W = $clog2(PERIOD_CLKS + 2 * WIDE_STEPS + 1);

  logic [PH_W-1:0]  phase_q, phase_d, ph_eff;
  logic [ACC_W-1:0] acc_q, acc_d, acc_b, sum;
  logic [POS_W-1:0] pos_q, pos_d, pos_b, dbl;
  logic [AMP_W-1:0] amp_q, amp_d, amp_sel;
  logic             ctr_q, ctr_d, start, tick;

  always_comb begin
    case (span_i)
      SPAN_NARROW: amp_sel = AMP_W'(NARROW_STEPS);
      SPAN_WIDE:   amp_sel = AMP_W'(WIDE_STEPS);
      default:     amp_sel = '0;
    endcase
  end

  // Next state: a restart acts as phase zero; phase zero reloads settings
  // and clears the fractional accumulator and the step position.
  always_comb begin
    ph_eff  = restart_i ? '0 : phase_q;
    start   = (ph_eff == '0);
    amp_d   = start ? amp_sel  : amp_q;
    ctr_d   = start ? center_i : ctr_q;
    acc_b   = start ? '0 : acc_q;
    pos_b   = start ? '0 : pos_q;
    dbl     = {amp_d, 1'b0};
    sum     = acc_b + ACC_W'(dbl);
    tick    = (sum >= ACC_W'(PERIOD_CLKS));
    acc_d   = tick ? (sum - ACC_W'(PERIOD_CLKS)) : sum;
    pos_d   = pos_b + POS_W'(tick);
    if (pos_d == dbl) pos_d = '0;
    phase_d = (ph_eff == PH_W'(PERIOD_CLKS - 1)) ? '0 : (ph_eff + PH_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      acc_q   <= '0;
      pos_q   <= '0;
      amp_q   <= '0;
      ctr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
      pos_q   <= pos_d;
      amp_q   <= amp_d;
      ctr_q   <= ctr_d;
    end
  end

  assign period_start_o = start;
  assign amp_nxt_o      = amp_d;
  assign ctr_nxt_o      = ctr_d;
  assign pos_nxt_o      = pos_d;
  assign amp_q_o        = amp_q;
  assign ctr_q_o        = ctr_q;
endmodule

// File: rtl/ssc_offset_map.sv
module ssc_offset_map #(
  parameter int AMP_W = 8,
  parameter int POS_W = AMP_W + 1,
  parameter int OFS_W = 9
) (
  input  logic                    spread_ni,
  input  logic                    center_i,
  input  logic [AMP_W-1:0]        amp_i,
  input  logic [POS_W-1:0]        pos_i,
  output logic signed [OFS_W-1:0] offset_o
);
  logic [POS_W-1:0] dbl, lvl;
  logic [AMP_W-1:0] half;

  always_comb begin
    dbl  = {amp_i, 1'b0};
    lvl  = (pos_i <= POS_W'(amp_i)) ? pos_i : (dbl - pos_i);
    half = amp_i >> 1;
    if (spread_ni)
      offset_o = '0;
    else if (center_i)
      offset_o = $signed(OFS_W'(half)) - $signed(OFS_W'(lvl));
    else
      offset_o = -$signed(OFS_W'(lvl));
  end
endmodule

// File: rtl/ssc_out_gate.sv
module ssc_out_gate (
  input  logic [1:0] out_en_i,
  output logic       grp_a_en_o,
  output logic       grp_b_en_o
);
  // {first, second}: 0x all off, 10 single group only, 11 both.
  assign grp_b_en_o = out_en_i[1];
  assign grp_a_en_o = out_en_i[1] & out_en_i[0];
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int PERIOD_CLKS  = 1000,
  parameter int NARROW_STEPS = 50,
  parameter int WIDE_STEPS   = 150,
  parameter int SYNC_STAGES  = 2,
  parameter int OFS_W        = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    spread_ni,
  input  logic [1:0]              span_i,
  input  logic                    center_i,
  input  logic                    restart_i,
  input  logic [1:0]              out_en_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    offset_vld_o,
  output logic signed [OFS_W-1:0] ref_offset_o,
  output logic                    grp_a_en_o,
  output logic                    grp_b_en_o
);
  localparam int AMP_W = $clog2(WIDE_STEPS + 1);
  localparam int POS_W = AMP_W + 1;

  logic                    restart_pulse;
  logic                    period_start;
  logic [AMP_W-1:0]        amp_nxt, cfg_amp;
  logic [POS_W-1:0]        pos_nxt;
  logic                    ctr_nxt, cfg_center;
  logic signed [OFS_W-1:0] offset_d, offset_q;
  logic                    vld_q;

  ssc_restart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (restart_i),
    .pulse_o (restart_pulse)
  );

  ssc_sweep_core #(
    .PERIOD_CLKS  (PERIOD_CLKS),
    .NARROW_STEPS (NARROW_STEPS),
    .WIDE_STEPS   (WIDE_STEPS),
    .AMP_W        (AMP_W),
    .POS_W        (POS_W)
  ) u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .restart_i      (restart_pulse),
    .span_i         (span_e'(span_i)),
    .center_i       (center_i),
    .period_start_o (period_start),
    .amp_nxt_o      (amp_nxt),
    .ctr_nxt_o      (ctr_nxt),
    .pos_nxt_o      (pos_nxt),
    .amp_q_o        (cfg_amp),
    .ctr_q_o        (cfg_center)
  );

  ssc_offset_map #(.AMP_W(AMP_W), .POS_W(POS_W), .OFS_W(OFS_W)) u_map (
    .spread_ni (spread_ni),
    .center_i  (ctr_nxt),
    .amp_i     (amp_nxt),
    .pos_i     (pos_nxt),
    .offset_o  (offset_d)
  );

  ssc_out_gate u_gate (
    .out_en_i   (out_en_i),
    .grp_a_en_o (grp_a_en_o),
    .grp_b_en_o (grp_b_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      offset_q <= offset_d;
      vld_q    <= 1'b1;
    end
  end

  assign offset_o     = offset_q;
  assign offset_vld_o = vld_q;
  assign ref_offset_o = '0;
endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk #(
  parameter int AMP_W = 8,
  parameter int OFS_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    spread_ni,
  input logic signed [OFS_W-1:0] offset_o,
  input logic                    offset_vld_o,
  input logic                    grp_a_en_o,
  input logic                    grp_b_en_o,
  input logic                    period_start,
  input logic                    restart_pulse,
  input logic [AMP_W-1:0]        cfg_amp,
  input logic                    cfg_center
);
  logic signed [OFS_W-1:0] amp_s, half_s;
  assign amp_s  = $signed(OFS_W'(cfg_amp));
  assign half_s = $signed(OFS_W'(cfg_amp >> 1));

  AST_VALID_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !offset_vld_o |=> offset_vld_o); // R10

  AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spread_ni |=> (offset_o == '0)); // R5

  AST_DOWN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_center |-> (offset_o <= 0 && offset_o >= -amp_s)); // R3

  AST_CENTER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_center |-> (offset_o <= half_s && offset_o >= -half_s)); // R4

  AST_RESTART_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_pulse && !spread_ni) |=> (offset_o == (cfg_center ? half_s : '0))); // R6

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(period_start) && !$past(spread_ni) && !$past(spread_ni, 2)) |->
    (offset_o == $past(offset_o) || offset_o == $past(offset_o) + 1 ||
     offset_o == $past(offset_o) - 1)); // R11

  AST_GROUP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_a_en_o |-> grp_b_en_o); // R9
endmodule

bind ssc_profile_gen ssc_profile_gen_chk #(.AMP_W(AMP_W), .OFS_W(OFS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .spread_ni     (spread_ni),
  .offset_o      (offset_o),
  .offset_vld_o  (offset_vld_o),
  .grp_a_en_o    (grp_a_en_o),
  .grp_b_en_o    (grp_b_en_o),
  .period_start  (period_start),
  .restart_pulse (restart_pulse),
  .cfg_amp       (cfg_amp),
  .cfg_center    (cfg_center)
);

// File: tb/ssc_profile_gen_test.sv
module ssc_profile_gen_test;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              spread_n;
  logic [1:0]        span;
  logic              center;
  logic              restart;
  logic [1:0]        out_en;
  logic signed [8:0] offset;
  logic              vld;
  logic signed [8:0] ref_ofs;
  logic              grp_a, grp_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ssc_profile_gen uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .spread_ni    (spread_n),
    .span_i       (span),
    .center_i     (center),
    .restart_i    (restart),
    .out_en_i     (out_en),
    .offset_o     (offset),
    .offset_vld_o (vld),
    .ref_offset_o (ref_ofs),
    .grp_a_en_o   (grp_a),
    .grp_b_en_o   (grp_b)
  );

  // {span[1:0], center, spread_n, edges[10:0], expected offset[8:0]}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 11'd1,    9'sd0},    // R3 start at zero
    {2'b00, 1'b0, 1'b0, 11'd250,  -9'sd25},  // R1
    {2'b00, 1'b0, 1'b0, 11'd505,  -9'sd50},  // R1 bottom
    {2'b00, 1'b0, 1'b0, 11'd999,  -9'sd1},   // R3 return
    {2'b00, 1'b0, 1'b0, 11'd1000, 9'sd0},    // R3 period end
    {2'b00, 1'b1, 1'b0, 11'd1,    9'sd25},   // R4 narrow start
    {2'b00, 1'b1, 1'b0, 11'd505,  -9'sd25},  // R4 narrow bottom
    {2'b01, 1'b0, 1'b0, 11'd500,  -9'sd150}, // R2 wide bottom
    {2'b01, 1'b0, 1'b0, 11'd100,  -9'sd30},  // R2 wide slope
    {2'b01, 1'b1, 1'b0, 11'd1,    9'sd75},   // R4 wide start
    {2'b01, 1'b1, 1'b0, 11'd500,  -9'sd75},  // R4 wide bottom
    {2'b10, 1'b0, 1'b0, 11'd500,  9'sd0},    // R2 no spread
    {2'b00, 1'b0, 1'b1, 11'd505,  9'sd0}     // R5 disabled
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] s, input logic c, input logic sn);
    @(negedge clk);
    rst_n = 1'b0; span = s; center = c; spread_n = sn; restart = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; spread_n = 1'b0; span = 2'b00; center = 1'b0;
    restart = 1'b0; out_en = 2'b00;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 offset in reset", offset, 0);
    check("R10 valid in reset", vld, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 valid after first edge", vld, 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      start(VEC[i][23:22], VEC[i][21], VEC[i][20]);
      repeat (int'(VEC[i][19:9])) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1-vector %0d (R2/R3/R4/R5)", i), offset, int'($signed(VEC[i][8:0])));
    end

    // R9: output enable decode
    for (int e = 0; e < 4; e++) begin
      out_en = 2'(e);
      #1;
      check($sformatf("R9 grp_a en=%0d", e), grp_a, (e == 3) ? 1 : 0);
      check($sformatf("R9 grp_b en=%0d", e), grp_b, (e >= 2) ? 1 : 0);
    end

    // R6: restart mid-sweep
    start(2'b00, 1'b0, 1'b0);
    repeat (505) @(posedge clk);
    @(negedge clk);
    check("R6 before restart", offset, -50);
    check("R8 reference offset", ref_ofs, 0);
    restart = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 after restart", offset, 0);
    repeat (250) @(posedge clk);
    @(negedge clk);
    check("R6 held level no re-restart", offset, -25);
    restart = 1'b0;

    // R7: settings change mid-period applies at next period
    start(2'b00, 1'b0, 1'b0);
    repeat (250) @(posedge clk);
    @(negedge clk);
    span = 2'b01; center = 1'b1;
    repeat (250) @(posedge clk);
    @(negedge clk);
    check("R7 old settings kept", offset, -50);
    check("R8 reference offset center", ref_ofs, 0);
    repeat (501) @(posedge clk);
    @(negedge clk);
    check("R7 new settings at period start", offset, 75);

    // R5: enable toggle, sweep keeps running
    start(2'b00, 1'b0, 1'b0);
    repeat (505) @(posedge clk);
    @(negedge clk);
    spread_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R5 forced zero", offset, 0);
    spread_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 resumes in place", offset, -50);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule